// File: doc/BRIEF.md
# Multiplexed Address/Data External Bus Controller

The controller turns single requests from an internal bus master into bus cycles on one shared external bus. That bus carries the address first and the data after it. The top bits of each request address pick one of three external regions. Every region has its own settings: data width (8 or 16 bits), access length (2 or 3 states), a wait mode, one optional address wait state, and zero to three data wait states. In the right wait mode, an external wait input can add further data wait states after the programmed ones.

Every bus cycle starts with an address phase. In that phase the full address is on the bus and the address latch strobe is high. The strobe falls when the data phase begins. In the data phase the read or write strobe is low. For a read the bus is released, and for a write the write data is driven. A 16-bit transfer to an 8-bit region runs as two bus cycles, one straight after the other, and the master sees one ready pulse at the end. A request whose address falls in no region is answered with a ready pulse flagged as an error, and no bus activity takes place.

The master gives a one-cycle request while the controller is idle. It then waits for the ready pulse before it issues the next request. The region settings are taken at the moment the request is accepted.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset the bus is idle. `ale` is 0, `rd_n` and `wr_n` are 1, `bus_oe` is 0, and `rdy` and `err` are 0.
- R2: The two top address bits select the region: 01 selects region 0, 10 selects region 1, and 11 selects region 2. The value 00 maps to no region. An unmapped request gives `rdy`=1 with `err`=1 in the cycle after the request, with no strobe and no bus drive.
- R3: The address phase begins in the cycle after acceptance. `ale` is 1, `bus_oe` is 1 and `bus_out` carries the address. The phase lasts one state plus any address wait state. `ale` falls exactly when a data strobe goes low.
- R4: A 2-state region runs exactly 2 states per bus cycle: one address state and one data state. The wait mode, both wait counts and `ext_wait` have no effect.
- R5: A 3-state region with wait mode 00 runs exactly 3 states per bus cycle (one address state and two data states), whatever the wait counts are.
- R6: A 3-state region with wait mode 01 adds the programmed address wait (0 or 1) to the address phase. It also adds the programmed data waits (0 to 3) to the data phase. `ext_wait` has no effect.
- R7: A 3-state region with wait mode 10 or 11 adds the programmed waits as in R6, then one extra data state for each cycle in which `ext_wait` is sampled high. `ext_wait` is sampled in the last programmed data wait, or in the first data state when the count is 0, and again in every extra state.
- R8: In the data phase of a read, `rd_n` is 0 and `bus_oe` is 0. In the data phase of a write, `wr_n` is 0, `bus_oe` is 1 and the write data is on the bus. The two strobes are never low together. A 16-bit access to a 16-bit region uses bits 15:0. A byte access uses bits 7:0, and a byte read returns `{8'h00, byte}`.
- R9: A 16-bit access to an 8-bit region runs two bus cycles with no gap between them. The first uses the even address and the upper byte, `req_wdata[15:8]`. The second uses the address with bit 0 set and the lower byte. A read returns the first byte in `rdata[15:8]`.
- R10: `rdy` is a one-cycle pulse in the cycle after the last bus state. For a mapped request `err`=0, and for a read `rdata` is valid in that same cycle. The total length of a transfer is the number of states of each bus cycle added up, and `rdy` stays 0 until that many cycles have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | One-cycle request, sampled while idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_w16 | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_addr | input | AW | Request address |
| req_wdata | input | 16 | Write data |
| rdy | output | 1 | Transfer done pulse |
| err | output | 1 | Unmapped address, valid with rdy |
| rdata | output | 16 | Read data, valid with rdy |
| cfg_wide | input | NREG | Per region: 1 = 16-bit data width |
| cfg_three | input | NREG | Per region: 1 = 3-state access |
| cfg_wmode | input | 2*NREG | Per region wait mode, bits [2i+1:2i] |
| cfg_awt | input | NREG | Per region address wait count (0/1) |
| cfg_dwt | input | 2*NREG | Per region data wait count, bits [2i+1:2i] |
| bus_out | output | AW | Shared bus drive value |
| bus_oe | output | 1 | Shared bus drive enable |
| bus_in | input | AW | Shared bus read value |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ext_wait | input | 1 | External wait request |

## Verification
The bench builds the controller with its default parameters: a 16-bit address and bus, and three regions. At that size the whole settings space can be swept. That covers every region, both widths, both access lengths, all four wait-mode codes, both address wait counts and all four data wait counts, under byte and 16-bit reads and writes. The external wait stretch is varied between zero and two states. The bench also holds `ext_wait` high in the modes that must ignore it, and sets the other regions to opposite values to show that each region's settings stand apart.

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl #(
  parameter int AW   = 16,
  parameter int NREG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            req_we,
  input  logic            req_w16,
  input  logic [AW-1:0]   req_addr,
  input  logic [15:0]     req_wdata,
  output logic            rdy,
  output logic            err,
  output logic [15:0]     rdata,
  input  logic [NREG-1:0] cfg_wide,
  input  logic [NREG-1:0] cfg_three,
  input  logic [2*NREG-1:0] cfg_wmode,
  input  logic [NREG-1:0] cfg_awt,
  input  logic [2*NREG-1:0] cfg_dwt,
  output logic [AW-1:0]   bus_out,
  output logic            bus_oe,
  input  logic [AW-1:0]   bus_in,
  output logic            ale,
  output logic            rd_n,
  output logic            wr_n,
  input  logic            ext_wait
);
  localparam int SW = $clog2(NREG + 1);

  typedef enum logic [2:0] {S_IDLE, S_T1, S_TA, S_T2, S_TW, S_TX, S_T3} st_t;
  st_t st;

  logic [SW-1:0] sel, ri;
  logic          hit;
  assign sel = req_addr[AW-1 -: SW];
  assign ri  = sel - 1'b1;
  assign hit = (sel != '0) && (sel <= SW'(NREG));

  logic          q_we, q_w16, q_wide, q_three, q_aw, q_hi;
  logic [1:0]    q_mode, q_dw, cnt;
  logic [AW-1:0] q_addr;
  logic [15:0]   q_wd;
  logic [7:0]    q_rhi;

  logic          prog, aw_e, ext_e, split, last, addr_ph, data_ph;
  logic [1:0]    dw_e;
  logic [AW-1:0] part_addr;
  logic [15:0]   wd, rv;

  assign prog    = q_three && (q_mode != 2'd0);
  assign aw_e    = prog && q_aw;
  assign dw_e    = prog ? q_dw : 2'd0;
  assign ext_e   = q_three && q_mode[1];
  assign split   = q_w16 && !q_wide;
  assign last    = (st == S_T2 && !q_three) || st == S_T3;
  assign addr_ph = (st == S_T1) || (st == S_TA);
  assign data_ph = (st == S_T2) || (st == S_TW) || (st == S_TX) || (st == S_T3);

  assign part_addr = split ? {q_addr[AW-1:1], q_hi} : q_addr;
  assign wd = (q_w16 && q_wide) ? q_wd :
              split ? {8'h00, (q_hi ? q_wd[7:0] : q_wd[15:8])} :
              {8'h00, q_wd[7:0]};
  assign rv = (q_w16 && q_wide) ? bus_in[15:0] :
              split ? {q_rhi, bus_in[7:0]} :
              {8'h00, bus_in[7:0]};

  assign ale     = addr_ph;
  assign bus_oe  = addr_ph || (data_ph && q_we);
  assign bus_out = addr_ph ? part_addr : (data_ph && q_we) ? AW'(wd) : '0;
  assign rd_n    = !(data_ph && !q_we);
  assign wr_n    = !(data_ph && q_we);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      rdy     <= 1'b0;
      err     <= 1'b0;
      rdata   <= '0;
      q_we    <= 1'b0;
      q_w16   <= 1'b0;
      q_wide  <= 1'b0;
      q_three <= 1'b0;
      q_aw    <= 1'b0;
      q_hi    <= 1'b0;
      q_mode  <= '0;
      q_dw    <= '0;
      cnt     <= '0;
      q_addr  <= '0;
      q_wd    <= '0;
      q_rhi   <= '0;
    end else begin
      rdy <= 1'b0;
      err <= 1'b0;
      case (st)
        S_IDLE: if (req && !rdy) begin
          if (!hit) begin
            rdy <= 1'b1;
            err <= 1'b1;
          end else begin
            q_we    <= req_we;
            q_w16   <= req_w16;
            q_addr  <= req_addr;
            q_wd    <= req_wdata;
            q_wide  <= cfg_wide[ri];
            q_three <= cfg_three[ri];
            q_aw    <= cfg_awt[ri];
            q_mode  <= cfg_wmode[{ri, 1'b0} +: 2];
            q_dw    <= cfg_dwt[{ri, 1'b0} +: 2];
            q_hi    <= 1'b0;
            st      <= S_T1;
          end
        end
        S_T1: st <= aw_e ? S_TA : S_T2;
        S_TA: st <= S_T2;
        S_T2: if (q_three) begin
          if (dw_e != 2'd0) begin
            cnt <= dw_e;
            st  <= S_TW;
          end else begin
            st <= (ext_e && ext_wait) ? S_TX : S_T3;
          end
        end
        S_TW: begin
          if (cnt == 2'd1) st <= (ext_e && ext_wait) ? S_TX : S_T3;
          else cnt <= cnt - 2'd1;
        end
        S_TX: if (!ext_wait) st <= S_T3;
        default: ;
      endcase
      if (last) begin
        if (split && !q_hi) begin
          q_rhi <= bus_in[7:0];
          q_hi  <= 1'b1;
          st    <= S_T1;
        end else begin
          if (!q_we) rdata <= rv;
          rdy <= 1'b1;
          st  <= S_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/mux_bus_ctrl_chk.sv
module mux_bus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic bus_oe,
  input logic rdy,
  input logic err,
  input logic three_q
);
  a_r3_ale_fall_opens_data: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (!rd_n || !wr_n));
  a_r3_addr_phase_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n && bus_oe));
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  a_r10_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);
  a_r10_rdy_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (rd_n && wr_n && !ale));
  a_r2_err_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> rdy);
  a_r4_two_state_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rd_n || !wr_n) && !three_q) |=> (rd_n && wr_n));
endmodule

bind mux_bus_ctrl mux_bus_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .bus_oe(bus_oe), .rdy(rdy), .err(err), .three_q(q_three)
);

// File: tb/mux_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module mux_bus_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, req_we = 0, req_w16 = 0, ext_wait = 0;
  logic [15:0] req_addr = 0, req_wdata = 0, bus_in = 0;
  logic [2:0] cfg_wide = 0, cfg_three = 0, cfg_awt = 0;
  logic [5:0] cfg_wmode = 0, cfg_dwt = 0;
  logic rdy, err, bus_oe, ale, rd_n, wr_n;
  logic [15:0] rdata, bus_out;
  int nchk = 0, nfail = 0, xsel = 0;

  always #2 clk = ~clk;

  mux_bus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_w16(req_w16),
    .req_addr(req_addr), .req_wdata(req_wdata), .rdy(rdy), .err(err), .rdata(rdata),
    .cfg_wide(cfg_wide), .cfg_three(cfg_three), .cfg_wmode(cfg_wmode),
    .cfg_awt(cfg_awt), .cfg_dwt(cfg_dwt), .bus_out(bus_out), .bus_oe(bus_oe),
    .bus_in(bus_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ext_wait(ext_wait)
  );

  bit e_ale[$], e_rd[$], e_wr[$], e_oe[$], e_ext[$];
  logic [15:0] e_bus[$], e_in[$];

  task automatic chk(input bit ok, input string msg);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic push(input bit a, input bit r, input bit w, input bit o,
                      input logic [15:0] b, input bit x, input logic [15:0] i);
    e_ale.push_back(a); e_rd.push_back(r); e_wr.push_back(w);
    e_oe.push_back(o); e_bus.push_back(b); e_ext.push_back(x); e_in.push_back(i);
  endtask

  task automatic txn(input int r, input bit wide, input bit three, input int mode,
                     input bit aw, input int dw, input bit w16, input bit we,
                     input int x, input logic [15:0] alow, input logic [15:0] wdv);
    logic [15:0] addr, pa, bv, iv, exp_rd;
    int parts, eaw, edw, ex, nd, ncyc;
    bit prog, extm;
    string tag;
    cfg_wide = ~{3{wide}}; cfg_three = ~{3{three}}; cfg_awt = ~{3{aw}};
    cfg_wmode = ~{3{2'(mode)}}; cfg_dwt = ~{3{2'(dw)}};
    cfg_wide[r] = wide; cfg_three[r] = three; cfg_awt[r] = aw;
    cfg_wmode[2*r +: 2] = 2'(mode); cfg_dwt[2*r +: 2] = 2'(dw);
    addr = {2'(r + 1), alow[13:0]};
    if (w16) addr[0] = 1'b0;
    parts = (w16 && !wide) ? 2 : 1;
    prog = three && mode != 0;
    extm = three && mode >= 2;
    eaw = prog ? int'(aw) : 0;
    edw = prog ? dw : 0;
    ex = extm ? x : 0;
    tag = !three ? "R4" : mode == 0 ? "R5" : mode == 1 ? "R6" : "R7";
    if (parts == 2) tag = {tag, "/R9"};
    exp_rd = 16'h0;
    for (int p = 0; p < parts; p++) begin
      pa = (parts == 2) ? {addr[15:1], 1'(p)} : addr;
      iv = 16'h5A3C ^ (16'h1111 * 16'(p + 1)) ^ alow;
      if (w16 && wide) bv = wdv;
      else if (parts == 2) bv = {8'h00, (p == 0) ? wdv[15:8] : wdv[7:0]};
      else bv = {8'h00, wdv[7:0]};
      if (w16 && wide) exp_rd = iv;
      else if (parts == 2) exp_rd = (p == 0) ? {iv[7:0], 8'h00} : {exp_rd[15:8], iv[7:0]};
      else exp_rd = {8'h00, iv[7:0]};
      for (int k = 0; k <= eaw; k++) push(1, 1, 1, 1, pa, 0, iv);
      nd = 1 + (three ? edw + ex + 1 : 0);
      for (int j = 0; j < nd; j++)
        push(0, we, !we, we, bv, extm ? (j >= edw && j < edw + ex) : 1'b1, iv);
    end
    ncyc = parts * ((three ? 3 : 2) + eaw + edw + ex);
    chk(e_ale.size() == ncyc, $sformatf("%s model length act %0d exp %0d", tag, e_ale.size(), ncyc));
    @(negedge clk);
    req = 1; req_we = we; req_w16 = w16; req_addr = addr; req_wdata = wdv;
    @(negedge clk);
    req = 0;
    for (int c = 1; e_ale.size() > 0; c++) begin
      bit ea, er, ew, eo; logic [15:0] eb;
      ea = e_ale.pop_front(); er = e_rd.pop_front(); ew = e_wr.pop_front();
      eo = e_oe.pop_front(); eb = e_bus.pop_front();
      ext_wait = e_ext.pop_front(); bus_in = e_in.pop_front();
      chk(ale == ea && rd_n == er && wr_n == ew && bus_oe == eo && rdy == 0 &&
          (!eo || bus_out == eb),
          $sformatf("%s/R3/R8 cycle %0d ale,rd_n,wr_n,oe,rdy act %b%b%b%b%b exp %b%b%b%b0 bus act %h exp %h",
                    tag, c, ale, rd_n, wr_n, bus_oe, rdy, ea, er, ew, eo, bus_out, eb));
      @(negedge clk);
    end
    ext_wait = 0;
    chk(rdy == 1 && err == 0, $sformatf("%s/R10 end rdy,err act %b%b exp 10 after %0d cycles", tag, rdy, err, ncyc));
    if (!we) chk(rdata == exp_rd, $sformatf("%s/R8 rdata act %h exp %h", tag, rdata, exp_rd));
    @(negedge clk);
    chk(rdy == 0 && ale == 0, $sformatf("R10 rdy pulse act %b exp 0", rdy));
  endtask

  initial begin
    #800000;
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ale == 0 && rd_n == 1 && wr_n == 1 && bus_oe == 0 && rdy == 0 && err == 0,
        $sformatf("R1 reset ale,rd_n,wr_n,oe,rdy,err act %b%b%b%b%b%b exp 011000",
                  ale, rd_n, wr_n, bus_oe, rdy, err));
    rst_n = 1;
    @(negedge clk);
    chk(ale == 0 && rd_n == 1 && wr_n == 1 && bus_oe == 0,
        $sformatf("R1 idle after release act %b%b%b%b exp 0110", ale, rd_n, wr_n, bus_oe));
    // R2 unmapped request
    req = 1; req_addr = 16'h1234; req_we = 1;
    @(negedge clk);
    req = 0;
    chk(rdy == 1 && err == 1 && ale == 0 && bus_oe == 0 && wr_n == 1,
        $sformatf("R2 unmapped rdy,err,ale,oe act %b%b%b%b exp 1100", rdy, err, ale, bus_oe));
    @(negedge clk);
    chk(rdy == 0 && err == 0 && ale == 0 && wr_n == 1,
        $sformatf("R2 no bus activity rdy,err,ale act %b%b%b exp 000", rdy, err, ale));
    for (int r = 0; r < 3; r++)
      for (int wide = 0; wide < 2; wide++)
        for (int three = 0; three < 2; three++)
          for (int mode = 0; mode < 4; mode++)
            for (int aw = 0; aw < 2; aw++)
              for (int dw = 0; dw < 4; dw++)
                for (int w16 = 0; w16 < 2; w16++)
                  for (int we = 0; we < 2; we++) begin
                    xsel++;
                    txn(r, wide[0], three[0], mode, aw[0], dw, w16[0], we[0], xsel % 3,
                        16'(xsel * 16'h0137), 16'(16'hC3A5 ^ (xsel * 16'h0B1D)));
                  end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule